// File: doc/BRIEF.md
# Paged Register Initialization Sequencer

After reset this block configures an external audio converter. It issues a fixed, ordered list of single-byte register transactions on a generic register-access port. Each transaction carries a device address, a register address and a data byte, and is accepted with a valid/ready handshake. A serial bus controller behind the port turns each transaction into bus traffic. The sequencer does not contain that controller.

The list follows the converter's ordering rules. The sequencer first selects register page 0 and writes the page-0 control registers. It then raises a clock-enable request and waits for an acknowledge before it writes the power-up register. Next it sets the transmit buffer transfer-disable bit, switches to page 2 and writes two transmit buffer bytes. It then returns to page 0 and clears the transfer-disable bit, which commits the buffered bytes. Optionally the sequencer reads the two buffer bytes back on page 2, compares them with the values written, and ends on page 0. A mismatch sets a sticky error flag, and the sequence still runs to the end. A done flag marks completion.

Top module: `codec_bringup_seq`

## Requirements
- R1: After reset is released, `txn_valid` and `clk_en_req` stay low for HOLDOFF_CYCLES clock edges. The first transaction is presented on the cycle after the HOLDOFF_CYCLES-th edge.
- R2: Each transaction drives `txn_dev` = DEV_ADDR (default 0xE0), the register address on `txn_reg`, the byte on `txn_data` and `txn_rd` (1 = read, 0 = write). These values hold steady while `txn_valid` is high and `txn_ready` is low. A transaction completes only on a cycle with both high.
- R3: The first write puts 0x00 into page-select register 0x7F. The sequencer then writes these registers in this order: 0x03=0x20, 0x04=0x00, 0x07=0x00, 0x09=0x01, 0x0D=0x00, 0x0E=0x00, 0x0F=0x22, 0x10=0x00, 0x11=0x00, 0x2D=0x02. Register 0x01 is not written before this list has finished.
- R4: `clk_en_req` rises one cycle after the sequencer reaches the clock step and stays high until reset. While the acknowledge is pending, no transaction is presented. The step completes on the first cycle on which both `clk_en_req` and `clk_en_ack` are high. The next transaction is the power-up write 0x01=0x37.
- R5: After power-up the sequencer writes 0x08=0x08 to set transfer-disable. It then writes 0x7F=0x02, followed by buffer writes 0x2E=BUF_BYTE0 (default 0xEE) and 0x2F=BUF_BYTE1 (default 0xFF).
- R6: After the buffer writes the sequencer writes 0x7F=0x00 and then 0x08=0x00.
- R7: With VERIFY_EN=1 the sequencer next writes 0x7F=0x02. It then reads 0x2E and 0x2F (`txn_rd`=1, `txn_data`=0x00). After each read handshake it waits for `rsp_valid` before moving on.
- R8: If `rsp_data` differs from the byte written earlier to the same register, `verify_err` rises on the next cycle and stays high until reset. The sequence continues either way.
- R9: The final write is 0x7F=0x00. `done` rises on the cycle after its handshake and stays high. `txn_valid` then stays low.
- R10: A synchronous reset taken mid-sequence clears `done`, `verify_err` and `clk_en_req` and restarts from the hold-off and the first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_valid | output | 1 | A transaction is presented |
| txn_ready | input | 1 | The port accepts the presented transaction |
| txn_rd | output | 1 | 1 = read, 0 = write |
| txn_dev | output | 8 | Device address |
| txn_reg | output | 8 | Register address |
| txn_data | output | 8 | Write data (0x00 on reads) |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 8 | Returned read byte |
| clk_en_req | output | 1 | Request to start the converter clocks |
| clk_en_ack | input | 1 | Clocks are running |
| done | output | 1 | Sequence complete |
| verify_err | output | 1 | Sticky read-back mismatch |

## Verification
The bench builds the block with HOLDOFF_CYCLES=5 and VERIFY_EN=1, and keeps the default buffer bytes and device address. The short hold-off makes two full passes and a reset in the middle of a pass cheap. With verification enabled, the read-back path and the sticky error are exercised: one pass returns correct bytes and the other corrupts the response for 0x2F. A stalling ready pattern, a delayed clock acknowledge and delayed read responses test that each transaction holds steady and that the sequence respects its ordering.

// File: rtl/bringup_pkg.sv
// Shared types for the register bring-up sequencer.
// Assumes at most 32 sequence steps (5-bit index is ample).
package bringup_pkg;

    typedef enum logic [1:0] {
        STEP_WR  = 2'd0,
        STEP_RD  = 2'd1,
        STEP_CLK = 2'd2
    } step_kind_e;

    typedef struct packed {
        step_kind_e  kind;
        logic [7:0]  addr;
        logic [7:0]  val;
    } step_t;

    localparam logic [7:0] PAGE_SEL_ADDR = 8'h7F;
    localparam logic [7:0] XFER_CTL_ADDR = 8'h08;

    // Number of table entries for the chosen variant.
    function automatic int num_steps(input bit verify_en);
        return verify_en ? 23 : 19;
    endfunction

    // Builds one table entry.
    function automatic step_t mk_step(input step_kind_e k, input logic [7:0] a, input logic [7:0] v);
        step_t s;
        s.kind = k;
        s.addr = a;
        s.val  = v;
        return s;
    endfunction

endpackage

// File: rtl/bringup_holdoff.sv
// Post-reset hold-off counter.
// Counts clock edges while en is high and flags go on the last one.
// Assumes HOLDOFF_CYCLES >= 1 and that en drops as soon as go is seen.
module bringup_holdoff #(
    parameter int HOLDOFF_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic go
);
    localparam int CW = $clog2(HOLDOFF_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign go = en && (cnt_q == CW'(HOLDOFF_CYCLES - 1));

    // Advance the count during the hold-off window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (en && !go)
            cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/bringup_table.sv
// Constant bring-up step table.
// Each entry is a write, a read (val holds the expected byte) or the
// clock-enable wait. Order encodes the converter's sequencing rules.
// Assumes idx stays below num_steps(VERIFY_EN).
module bringup_table
    import bringup_pkg::*;
#(
    parameter int         IW        = 5,
    parameter logic [7:0] BUF_BYTE0 = 8'hEE,
    parameter logic [7:0] BUF_BYTE1 = 8'hFF
) (
    input  logic [IW-1:0] idx,
    output step_t         step
);
    // Decode the index into its step.
    always_comb begin
        case (int'(idx))
            0:  step = mk_step(STEP_WR,  PAGE_SEL_ADDR, 8'h00); // page 0
            1:  step = mk_step(STEP_WR,  8'h03, 8'h20);         // port A format
            2:  step = mk_step(STEP_WR,  8'h04, 8'h00);         // port A clocking
            3:  step = mk_step(STEP_WR,  8'h07, 8'h00);         // tx divider
            4:  step = mk_step(STEP_WR,  8'h09, 8'h01);         // tx status source
            5:  step = mk_step(STEP_WR,  8'h0D, 8'h00);         // rx input select
            6:  step = mk_step(STEP_WR,  8'h0E, 8'h00);         // rx clocking
            7:  step = mk_step(STEP_WR,  8'h0F, 8'h22);         // rx PLL
            8:  step = mk_step(STEP_WR,  8'h10, 8'h00);
            9:  step = mk_step(STEP_WR,  8'h11, 8'h00);
            10: step = mk_step(STEP_WR,  8'h2D, 8'h02);         // converter source
            11: step = mk_step(STEP_CLK, 8'h00, 8'h00);         // wait for clocks
            12: step = mk_step(STEP_WR,  8'h01, 8'h37);         // power-up
            13: step = mk_step(STEP_WR,  XFER_CTL_ADDR, 8'h08); // lock tx buffer
            14: step = mk_step(STEP_WR,  PAGE_SEL_ADDR, 8'h02);
            15: step = mk_step(STEP_WR,  8'h2E, BUF_BYTE0);
            16: step = mk_step(STEP_WR,  8'h2F, BUF_BYTE1);
            17: step = mk_step(STEP_WR,  PAGE_SEL_ADDR, 8'h00);
            18: step = mk_step(STEP_WR,  XFER_CTL_ADDR, 8'h00); // commit buffer
            19: step = mk_step(STEP_WR,  PAGE_SEL_ADDR, 8'h02);
            20: step = mk_step(STEP_RD,  8'h2E, BUF_BYTE0);
            21: step = mk_step(STEP_RD,  8'h2F, BUF_BYTE1);
            22: step = mk_step(STEP_WR,  PAGE_SEL_ADDR, 8'h00);
            default: step = mk_step(STEP_WR, PAGE_SEL_ADDR, 8'h00);
        endcase
    end
endmodule

// File: rtl/bringup_verify.sv
// Sticky read-back comparator.
// On each strobe compares the returned byte with the expected one and
// latches any mismatch until reset.
module bringup_verify (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe,
    input  logic [7:0] got,
    input  logic [7:0] expect_byte,
    output logic       err
);
    // Latch a mismatch and keep it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (strobe && (got != expect_byte))
            err <= 1'b1;
    end
endmodule

// File: rtl/codec_bringup_seq.sv
// Register bring-up sequencer for an external audio converter.
// Waits a hold-off after reset, then walks the step table. It issues one
// transaction at a time on a valid/ready port, waits for a clock-enable
// acknowledge at the clock step, and checks read-backs when enabled.
// Assumes the port returns exactly one rsp_valid pulse per accepted read.
module codec_bringup_seq
    import bringup_pkg::*;
#(
    parameter int         HOLDOFF_CYCLES = 16,
    parameter bit         VERIFY_EN      = 1'b1,
    parameter logic [7:0] DEV_ADDR       = 8'hE0,
    parameter logic [7:0] BUF_BYTE0      = 8'hEE,
    parameter logic [7:0] BUF_BYTE1      = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       txn_valid,
    input  logic       txn_ready,
    output logic       txn_rd,
    output logic [7:0] txn_dev,
    output logic [7:0] txn_reg,
    output logic [7:0] txn_data,
    input  logic       rsp_valid,
    input  logic [7:0] rsp_data,
    output logic       clk_en_req,
    input  logic       clk_en_ack,
    output logic       done,
    output logic       verify_err
);
    localparam int NUM_STEPS = num_steps(VERIFY_EN);
    localparam int IW        = $clog2(NUM_STEPS);

    typedef enum logic [1:0] {ST_HOLD, ST_RUN, ST_RESP, ST_DONE} state_e;

    state_e        state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic          req_q;
    logic          go;
    logic          adv;
    logic          last;
    step_t         step;

    bringup_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) holdoff_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_HOLD),
        .go    (go)
    );

    bringup_table #(.IW(IW), .BUF_BYTE0(BUF_BYTE0), .BUF_BYTE1(BUF_BYTE1)) table_i (
        .idx  (idx_q),
        .step (step)
    );

    generate
        if (VERIFY_EN) begin : g_verify
            bringup_verify verify_i (
                .clk         (clk),
                .rst_n       (rst_n),
                .strobe      (state_q == ST_RESP && rsp_valid),
                .got         (rsp_data),
                .expect_byte (step.val),
                .err         (verify_err)
            );
        end else begin : g_noverify
            assign verify_err = 1'b0;
        end
    endgenerate

    assign last = (idx_q == IW'(NUM_STEPS - 1));

    // Next-state and step-advance decision.
    always_comb begin
        state_d = state_q;
        adv     = 1'b0;
        case (state_q)
            ST_HOLD: if (go) state_d = ST_RUN;
            ST_RUN: begin
                case (step.kind)
                    STEP_CLK: adv = req_q && clk_en_ack;
                    STEP_WR:  adv = txn_ready;
                    STEP_RD:  if (txn_ready) state_d = ST_RESP;
                    default:  adv = 1'b0;
                endcase
            end
            ST_RESP: adv = rsp_valid;
            default: state_d = ST_DONE;
        endcase
        if (adv)
            state_d = last ? ST_DONE : ST_RUN;
        idx_d = (adv && !last) ? idx_q + IW'(1) : idx_q;
    end

    // Sequencer registers; the clock request is sticky once raised.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            idx_q   <= '0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            req_q   <= req_q | (state_q == ST_RUN && step.kind == STEP_CLK);
        end
    end

    assign txn_valid  = (state_q == ST_RUN) && (step.kind != STEP_CLK);
    assign txn_rd     = (step.kind == STEP_RD);
    assign txn_dev    = DEV_ADDR;
    assign txn_reg    = step.addr;
    assign txn_data   = (step.kind == STEP_RD) ? 8'h00 : step.val;
    assign clk_en_req = req_q;
    assign done       = (state_q == ST_DONE);
endmodule

// File: rtl/codec_bringup_seq_chk.sv
// Port-level property checker for the bring-up sequencer, bound to the top.
module codec_bringup_seq_chk #(
    parameter logic [7:0] DEV_ADDR = 8'hE0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       txn_valid,
    input logic       txn_ready,
    input logic       txn_rd,
    input logic [7:0] txn_dev,
    input logic [7:0] txn_reg,
    input logic [7:0] txn_data,
    input logic       clk_en_req,
    input logic       done,
    input logic       verify_err
);
    // R2
    stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_reg) && $stable(txn_data) && $stable(txn_rd));

    // R2
    dev_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_dev == DEV_ADDR);

    // R4
    req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_req |=> clk_en_req);

    // R4
    req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en_req) |-> !txn_valid);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verify_err |=> verify_err);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !txn_valid && clk_en_req);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

bind codec_bringup_seq codec_bringup_seq_chk #(.DEV_ADDR(DEV_ADDR)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_valid  (txn_valid),
    .txn_ready  (txn_ready),
    .txn_rd     (txn_rd),
    .txn_dev    (txn_dev),
    .txn_reg    (txn_reg),
    .txn_data   (txn_data),
    .clk_en_req (clk_en_req),
    .done       (done),
    .verify_err (verify_err)
);

// File: tb/codec_bringup_seq_tb_top.sv
// Bench: behavioural queue model stepped at every clock and compared with
// the ports on every falling edge, plus a simple register-slave model.
module codec_bringup_seq_tb_top;
    localparam int HOLD    = 5;
    localparam int ACK_DLY = 6;

    typedef struct {
        int         k;      // 0 write, 1 read, 2 clock wait
        logic [7:0] r;
        logic [7:0] d;
        string      tag;
    } mstep_t;

    typedef struct {
        logic       rd;
        logic [7:0] r;
        logic [7:0] d;
    } txn_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_valid, txn_rd;
    logic       txn_ready = 1'b0;
    logic [7:0] txn_dev, txn_reg, txn_data;
    logic       rsp_valid = 1'b0;
    logic [7:0] rsp_data = 8'h00;
    logic       clk_en_req, done, verify_err;
    logic       clk_en_ack = 1'b0;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    // model state
    mstep_t q[$];
    int     ph;      // 0 hold, 1 run, 2 resp, 3 done
    int     hc;
    bit     req_m, err_m, mid;

    // slave state
    logic [7:0] mem [256];
    logic [7:0] page;
    int         rsp_cnt, ack_cnt;
    logic [7:0] rsp_reg;
    txn_t       log_q[$];
    bit         corrupt = 1'b0;
    bit         rst_next = 1'b0;

    always #5 clk = ~clk;

    codec_bringup_seq #(.HOLDOFF_CYCLES(HOLD), .VERIFY_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_rd(txn_rd),
        .txn_dev(txn_dev), .txn_reg(txn_reg), .txn_data(txn_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .clk_en_req(clk_en_req), .clk_en_ack(clk_en_ack),
        .done(done), .verify_err(verify_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic add(input int k, input logic [7:0] r, input logic [7:0] d, input string tag);
        mstep_t s;
        s.k = k; s.r = r; s.d = d; s.tag = tag;
        q.push_back(s);
    endtask

    // Expected step list, written from the requirements.
    task automatic build();
        q.delete();
        add(0, 8'h7F, 8'h00, "R3"); add(0, 8'h03, 8'h20, "R3"); add(0, 8'h04, 8'h00, "R3");
        add(0, 8'h07, 8'h00, "R3"); add(0, 8'h09, 8'h01, "R3"); add(0, 8'h0D, 8'h00, "R3");
        add(0, 8'h0E, 8'h00, "R3"); add(0, 8'h0F, 8'h22, "R3"); add(0, 8'h10, 8'h00, "R3");
        add(0, 8'h11, 8'h00, "R3"); add(0, 8'h2D, 8'h02, "R3");
        add(2, 8'h00, 8'h00, "R4"); add(0, 8'h01, 8'h37, "R4");
        add(0, 8'h08, 8'h08, "R5"); add(0, 8'h7F, 8'h02, "R5");
        add(0, 8'h2E, 8'hEE, "R5"); add(0, 8'h2F, 8'hFF, "R5");
        add(0, 8'h7F, 8'h00, "R6"); add(0, 8'h08, 8'h00, "R6");
        add(0, 8'h7F, 8'h02, "R7"); add(1, 8'h2E, 8'hEE, "R7"); add(1, 8'h2F, 8'hFF, "R7");
        add(0, 8'h7F, 8'h00, "R9");
    endtask

    task automatic pop();
        void'(q.pop_front());
        ph = (q.size() == 0) ? 3 : 1;
    endtask

    // Compare all outputs with the model's expectation.
    task automatic compare();
        string t;
        bit ev;
        ev = (ph == 1) && (q[0].k != 2);
        if (ph == 0)      t = mid ? "R10" : "R1";
        else if (ph == 3) t = "R9";
        else              t = q[0].tag;
        chk(t, "txn_valid", int'(txn_valid), int'(ev));
        chk((ph == 0 && mid) ? "R10" : "R4", "clk_en_req", int'(clk_en_req), int'(req_m));
        chk((ph == 0 && mid) ? "R10" : "R9", "done", int'(done), int'(ph == 3));
        chk((ph == 0 && mid) ? "R10" : "R8", "verify_err", int'(verify_err), int'(err_m));
        if (ev && txn_valid) begin
            chk("R2", "txn_dev", int'(txn_dev), 'hE0);
            chk(t, "txn_rd", int'(txn_rd), int'(q[0].k == 1));
            chk(t, "txn_reg", int'(txn_reg), int'(q[0].r));
            chk(t, "txn_data", int'(txn_data), (q[0].k == 1) ? 0 : int'(q[0].d));
        end
    endtask

    // One falling-edge step: compare, drive, log, advance model.
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > 1) compare();
        rst_n = rst_next;
        if (!rst_n) begin
            txn_ready = 1'b0; clk_en_ack = 1'b0; rsp_valid = 1'b0;
            page = 8'h00; rsp_cnt = 0; ack_cnt = 0; log_q.delete();
        end else begin
            txn_ready = (cyc % 4) != 1;
            if (clk_en_req) ack_cnt++;
            clk_en_ack = ack_cnt > ACK_DLY;
            rsp_valid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data = mem[rsp_reg] ^ ((corrupt && rsp_reg == 8'h2F) ? 8'h01 : 8'h00);
                end
            end
            if (txn_valid && txn_ready) begin
                txn_t x;
                x.rd = txn_rd; x.r = txn_reg; x.d = txn_data;
                log_q.push_back(x);
                if (txn_rd) begin
                    rsp_cnt = 3; rsp_reg = txn_reg;
                end else if (txn_reg == 8'h7F) page = txn_data;
                else if (page == 8'h02) mem[txn_reg] = txn_data;
            end
        end
        // model advance for the coming rising edge
        if (!rst_n) begin
            ph = 0; hc = 0; req_m = 0; err_m = 0; build();
        end else begin
            case (ph)
                0: begin
                    hc++;
                    if (hc == HOLD) begin ph = 1; mid = 0; end
                end
                1: begin
                    if (q[0].k == 2) begin
                        if (req_m && clk_en_ack) pop();
                        req_m = 1;
                    end else if (q[0].k == 0) begin
                        if (txn_ready) pop();
                    end else if (txn_ready) ph = 2;
                end
                2: if (rsp_valid) begin
                    if (rsp_data != q[0].d) err_m = 1;
                    pop();
                end
                default: ;
            endcase
        end
    endtask

    task automatic run_until_done();
        int n = 0;
        while (ph != 3 && n < 3000) begin tick(); n++; end
        if (ph != 3) begin
            fails++;
            $display("FAIL R9 watchdog: actual not-done expected done");
        end
        repeat (5) tick();
    endtask

    // Check the accepted transaction log against the expected order.
    task automatic check_log();
        mstep_t ref_q[$];
        build();
        foreach (q[i]) if (q[i].k != 2) ref_q.push_back(q[i]);
        chk("R9", "transaction count", log_q.size(), ref_q.size());
        for (int i = 0; i < ref_q.size() && i < log_q.size(); i++) begin
            chk(ref_q[i].tag, "log reg", int'(log_q[i].r), int'(ref_q[i].r));
            chk(ref_q[i].tag, "log rd", int'(log_q[i].rd), int'(ref_q[i].k == 1));
        end
        ph = 3; q.delete();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mid = 0;
        // pass A: clean read-back
        rst_next = 0;
        repeat (3) tick();
        rst_next = 1;
        run_until_done();
        chk("R8", "no error on clean read-back", int'(verify_err), 0);
        chk("R9", "done after pass A", int'(done), 1);
        check_log();
        // pass B: reset, then mid-sequence reset, then corrupted read-back
        rst_next = 0;
        repeat (2) tick();
        corrupt = 1;
        rst_next = 1;
        for (int n = 0; n < 3000 && !(ph == 1 && q.size() <= 15); n++) tick();
        rst_next = 0;
        mid = 1;
        tick();
        rst_next = 1;
        tick();
        chk("R10", "restart clears clk_en_req", int'(clk_en_req), 0);
        run_until_done();
        chk("R8", "sticky error on bad read-back", int'(verify_err), 1);
        chk("R8", "sequence still finishes", int'(done), 1);
        check_log();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule